// File: doc/BRIEF.md
# Peak-and-Hold Current Regulator Controller

This block is the digital controller for one inductive-load channel. It switches a gate-drive output on and off so that the load current follows a peak-and-hold profile. It never sees the current itself. It drives a two-bit reference code to an external DAC and reads back a single comparator bit that reports whether the load current is above that reference. When the comparator trips, the controller turns the driver off for a programmable fixed off-time and then turns it on again. This gives peak-current control with a fixed off-time.

Four regulation modes are available. The first is no regulation, where the output simply follows the enable. The second is hold-only. The third is peak-and-hold where the peak phase ends at the first trip. The fourth is peak-and-hold where the peak phase lasts for a programmed time. After every turn-on, whether it came from the enable or from the end of an off-time, the comparator is ignored for a fixed blanking window. This stops switching transients from ending the on-phase early.

All timing counts a microsecond tick, which is derived by dividing the system clock by the `CLK_PER_US` parameter. One tick equals one clock when `CLK_PER_US` is 1.

Top module: `phold_ctrl`

## Requirements
- R1: With mode code 00 (no regulation), `gate_on` equals `chan_en` delayed by one clock, and `cur_above` has no effect.
- R2: With mode code 01 (hold only), `sel_peak` stays low and the channel cycles at the hold level. It stays on until `cur_above` is honoured, then stays off for the off-time, then turns on again, for as long as `chan_en` is high.
- R3: With mode code 10 (peak, minimum time), `sel_peak` is high from turn-on until the first trip. It falls in the same cycle that `gate_on` falls, and it stays low for the rest of the enable period.
- R4: With mode code 11 (peak, programmed time), `sel_peak` stays high through any number of trip and off-time cycles. It falls when the peak time has elapsed, counted from the clock edge at which the rising enable is taken, and after that the channel regulates as in R2.
- R5: The off-time code `cfg_toff` selects 100, 200, 300 or 400 ticks for codes 00 to 11. `gate_on` is low for exactly that many clocks (at one tick per clock) and then rises.
- R6: The peak-time code `cfg_tpk` selects (code+2)×400 ticks, which is 800 to 3600. `sel_peak` is high for exactly that many clocks after the turn-on edge.
- R7: For 20 ticks after every turn-on, whether external or internal, `cur_above` is ignored. With the comparator held high, an on-phase therefore lasts exactly 21 clocks.
- R8: A low `chan_en` forces `gate_on` and `sel_peak` low at the next edge, whatever the state. A new rising enable then turns the output on at the next edge, without waiting out any remaining off-time.
- R9: While `rst_n` is low, `gate_on` and `sel_peak` are low.
- R10: `ref_code` carries `cfg_ipk` while `sel_peak` is high and `cfg_ihd` while it is low. The peak codes 00 to 11 stand for 1.2, 1.8, 2.4 and 3.6 A. The hold codes 00 to 11 stand for 0.7, 1, 1.4 and 2 A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | External channel command, high means on |
| cur_above | input | 1 | Comparator: load current above the selected reference |
| cfg_mode | input | 2 | Regulation mode code |
| cfg_ipk | input | 2 | Peak current code |
| cfg_ihd | input | 2 | Hold current code |
| cfg_toff | input | 2 | Fixed off-time code |
| cfg_tpk | input | 3 | Peak time code |
| sel_peak | output | 1 | High while the peak threshold is selected |
| ref_code | output | 2 | Reference code to the DAC |
| gate_on | output | 1 | Gate drive for the power switch |

## Verification
The hardest situation to reach is the end of the timed peak phase while the channel is cycling through internal turn-ons. At that point the peak timer, the off-time timer and the blanking window all run at once. The stimulus holds the comparator high throughout, so every on-phase lasts exactly 21 clocks and every off-phase lasts exactly the coded off-time. This makes the edge at which the peak code must hand over to the hold code, and the turn-on edges of the internal cycles, known in advance. A separate run releases the comparator inside the blanking window to show that an early trip has no effect.

// File: rtl/phold_pkg.sv
package phold_pkg;

  typedef enum logic [1:0] {
    MODE_DIRECT = 2'b00,
    MODE_HOLD   = 2'b01,
    MODE_PKMIN  = 2'b10,
    MODE_PKTIME = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_DRIVE = 2'b01,
    ST_REST  = 2'b10
  } state_e;

  // power-up configuration values a surrounding register file would load
  localparam logic [1:0] DEF_MODE = 2'b00;
  localparam logic [1:0] DEF_IPK  = 2'b10;
  localparam logic [1:0] DEF_IHD  = 2'b01;
  localparam logic [1:0] DEF_TOFF = 2'b01;
  localparam logic [2:0] DEF_TPK  = 3'b101;

  function automatic int unsigned off_ticks(input logic [1:0] code, input int unsigned step);
    return (int'(code) + 1) * step;
  endfunction

  function automatic int unsigned peak_ticks(input logic [2:0] code, input int unsigned step);
    return (int'(code) + 2) * step;
  endfunction

endpackage

// File: rtl/phold_tick.sv
module phold_tick #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/phold_timer.sv
module phold_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero,
  output logic         expire
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load | (tick & (cnt_q != '0));

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero   = (cnt_q == '0);
  assign expire = tick & (cnt_q == W'(1));
endmodule

// File: rtl/phold_ctrl.sv
module phold_ctrl
  import phold_pkg::*;
#(
  parameter int CLK_PER_US   = 100,
  parameter int BLANK_US     = 20,
  parameter int OFF_STEP_US  = 100,
  parameter int PEAK_STEP_US = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chan_en,
  input  logic       cur_above,
  input  logic [1:0] cfg_mode,
  input  logic [1:0] cfg_ipk,
  input  logic [1:0] cfg_ihd,
  input  logic [1:0] cfg_toff,
  input  logic [2:0] cfg_tpk,
  output logic       sel_peak,
  output logic [1:0] ref_code,
  output logic       gate_on
);
  localparam int PH_MAX = (BLANK_US > 4 * OFF_STEP_US) ? BLANK_US : 4 * OFF_STEP_US;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int PK_W   = $clog2(9 * PEAK_STEP_US + 1);

  logic tick;
  state_e state_q, state_d;
  logic peak_q, peak_d;
  logic ph_load, pk_load;
  logic [PH_W-1:0] ph_val;
  logic [PK_W-1:0] pk_val;
  logic ph_zero, ph_expire, pk_zero, pk_expire;
  mode_e mode;
  logic trip;

  phold_tick #(.DIV(CLK_PER_US)) tick_i (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  // blanking window and off-time share one timer: they never overlap
  phold_timer #(.W(PH_W)) phase_tmr_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(ph_load),
    .load_val(ph_val), .zero(ph_zero), .expire(ph_expire)
  );

  phold_timer #(.W(PK_W)) peak_tmr_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(pk_load),
    .load_val(pk_val), .zero(pk_zero), .expire(pk_expire)
  );

  assign mode   = mode_e'(cfg_mode);
  assign trip   = cur_above & ph_zero & (mode != MODE_DIRECT);
  assign pk_val = PK_W'(peak_ticks(cfg_tpk, PEAK_STEP_US));

  always_comb begin
    state_d = state_q;
    peak_d  = peak_q;
    ph_load = 1'b0;
    ph_val  = PH_W'(BLANK_US);
    pk_load = 1'b0;
    // R4: timed peak phase ends on expiry of the peak timer
    if (pk_expire && mode == MODE_PKTIME) peak_d = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (chan_en) begin
          state_d = ST_DRIVE;
          ph_load = 1'b1;
          pk_load = 1'b1;
          peak_d  = (mode == MODE_PKMIN) || (mode == MODE_PKTIME);
        end
      end
      ST_DRIVE: begin
        if (trip) begin
          state_d = ST_REST;
          ph_load = 1'b1;
          ph_val  = PH_W'(off_ticks(cfg_toff, OFF_STEP_US));
          if (mode == MODE_PKMIN) peak_d = 1'b0;  // R3 handover at first trip
        end
      end
      ST_REST: begin
        if (ph_expire || mode == MODE_DIRECT) begin
          state_d = ST_DRIVE;   // internal turn-on, blanking reloaded (R7)
          ph_load = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (!chan_en) begin           // R8
      state_d = ST_IDLE;
      peak_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      peak_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      peak_q  <= peak_d;
    end
  end

  assign gate_on  = (state_q == ST_DRIVE);
  assign sel_peak = peak_q;
  assign ref_code = peak_q ? cfg_ipk : cfg_ihd;

  logic unused_ok;
  assign unused_ok = pk_zero;
endmodule

// File: rtl/phold_ctrl_chk.sv
module phold_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       chan_en,
  input logic [1:0] cfg_mode,
  input logic       gate_on,
  input logic       sel_peak
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_disable_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> (!gate_on && !sel_peak));

  assert_blank_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_on) && chan_en) |=> gate_on);

  assert_rest_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $fell(gate_on) && $past(chan_en) && chan_en && cfg_mode != 2'b00) |=> !gate_on);

  assert_direct_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && cfg_mode == 2'b00 && $past(cfg_mode) == 2'b00 && $past(chan_en)) |-> gate_on);

  assert_pkmin_handover_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $fell(sel_peak) && cfg_mode == 2'b10 && $past(cfg_mode) == 2'b10 && $past(chan_en))
      |-> !gate_on);
endmodule

bind phold_ctrl phold_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .cfg_mode(cfg_mode),
  .gate_on(gate_on), .sel_peak(sel_peak)
);

// File: tb/phold_ctrl_tb_top.sv
`timescale 1ns/1ps
module phold_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic chan_en, cur_above;
  logic [1:0] cfg_mode, cfg_ipk, cfg_ihd, cfg_toff;
  logic [2:0] cfg_tpk;
  logic sel_peak, gate_on;
  logic [1:0] ref_code;
  int total = 0;
  int bad = 0;
  int pos;

  always #5 clk = ~clk;

  phold_ctrl #(.CLK_PER_US(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .cur_above(cur_above),
    .cfg_mode(cfg_mode), .cfg_ipk(cfg_ipk), .cfg_ihd(cfg_ihd),
    .cfg_toff(cfg_toff), .cfg_tpk(cfg_tpk),
    .sel_peak(sel_peak), .ref_code(ref_code), .gate_on(gate_on)
  );

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // advance to just after turn-on edge P<k>
  task automatic goto(input int k);
    step(k - pos);
    pos = k;
  endtask

  task automatic start(input logic [1:0] m, input logic [1:0] toff, input logic [2:0] tpk,
                       input logic [1:0] ipk, input logic [1:0] ihd, input logic cur);
    chan_en = 1'b0;
    step(2);
    cfg_mode = m; cfg_toff = toff; cfg_tpk = tpk; cfg_ipk = ipk; cfg_ihd = ihd;
    cur_above = cur;
    chan_en = 1'b1;
    step(1);
    pos = 0;
  endtask

  task automatic t_reset;
    chk(gate_on, 0, "R9 gate in reset");
    chk(sel_peak, 0, "R9 sel in reset");
  endtask

  task automatic t_direct;
    start(2'b00, 2'b00, 3'b000, 2'b10, 2'b01, 1'b1);
    chk(gate_on, 1, "R1 on after enable");
    goto(200);
    chk(gate_on, 1, "R1 comparator ignored");
    chk(sel_peak, 0, "R1 no peak select");
    chan_en = 1'b0;
    step(1);
    chk(gate_on, 0, "R1 follows enable low");
  endtask

  task automatic t_hold;
    start(2'b01, 2'b00, 3'b000, 2'b11, 2'b10, 1'b1);
    chk(gate_on, 1, "R2 on at start");
    chk(sel_peak, 0, "R2 hold select");
    chk(ref_code, 2, "R10 hold code out");
    goto(20);  chk(gate_on, 1, "R7 external blanking");
    goto(21);  chk(gate_on, 0, "R2 off after trip");
    goto(120); chk(gate_on, 0, "R5 off 100 ticks");
    goto(121); chk(gate_on, 1, "R5 on after off-time");
    goto(141); chk(gate_on, 1, "R7 internal blanking");
    goto(142); chk(gate_on, 0, "R2 second trip");
  endtask

  task automatic t_blank;
    start(2'b01, 2'b00, 3'b000, 2'b00, 2'b00, 1'b1);
    goto(15);
    cur_above = 1'b0;
    goto(40);
    chk(gate_on, 1, "R7 early trip ignored");
  endtask

  task automatic t_offmax;
    start(2'b01, 2'b11, 3'b000, 2'b00, 2'b00, 1'b1);
    goto(420); chk(gate_on, 0, "R5 off 400 ticks");
    goto(421); chk(gate_on, 1, "R5 on after 400");
  endtask

  task automatic t_pkmin;
    start(2'b10, 2'b00, 3'b000, 2'b01, 2'b11, 1'b1);
    chk(sel_peak, 1, "R3 peak first");
    chk(ref_code, 1, "R10 peak code out");
    goto(20);  chk(sel_peak, 1, "R3 peak until trip");
    goto(21);  chk(sel_peak, 0, "R3 hold after trip");
    chk(gate_on, 0, "R3 off at handover");
    chk(ref_code, 3, "R10 hold code after handover");
    goto(121); chk(gate_on, 1, "R3 back on");
    chk(sel_peak, 0, "R3 stays hold");
  endtask

  task automatic t_pktime;
    start(2'b11, 2'b00, 3'b000, 2'b10, 2'b01, 1'b1);
    goto(21);  chk(gate_on, 0, "R4 off-time in peak");
    chk(sel_peak, 1, "R4 peak kept over trip");
    goto(799); chk(sel_peak, 1, "R6 peak before 800");
    goto(800); chk(sel_peak, 0, "R6 hold at 800");
    chk(ref_code, 1, "R4 hold code after peak");
  endtask

  task automatic t_pklong;
    start(2'b11, 2'b00, 3'b111, 2'b10, 2'b01, 1'b0);
    goto(3599); chk(sel_peak, 1, "R6 peak before 3600");
    goto(3600); chk(sel_peak, 0, "R6 hold at 3600");
    chk(gate_on, 1, "R4 stays on without trip");
  endtask

  task automatic t_disable;
    start(2'b11, 2'b11, 3'b000, 2'b00, 2'b00, 1'b1);
    goto(50);
    chan_en = 1'b0;
    goto(51);
    chk(gate_on, 0, "R8 off when disabled");
    chk(sel_peak, 0, "R8 peak cleared");
    chan_en = 1'b1;
    goto(52);
    chk(gate_on, 1, "R8 fresh turn-on");
    chk(sel_peak, 1, "R8 fresh peak");
    chan_en = 1'b0;
    goto(53);
    chk(gate_on, 0, "R8 off from drive");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; chan_en = 1'b0; cur_above = 1'b0;
    cfg_mode = 2'b00; cfg_ipk = 2'b10; cfg_ihd = 2'b01; cfg_toff = 2'b01; cfg_tpk = 3'b101;
    pos = 0;
    step(3);
    t_reset;
    rst_n = 1'b1;
    step(2);
    t_direct;
    t_hold;
    t_blank;
    t_offmax;
    t_pkmin;
    t_pktime;
    t_pklong;
    t_disable;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule